// File: doc/BRIEF.md
# Register-Offset Load/Store Instruction Decoder

This block looks at a 16-bit instruction word and recognises the load/store class whose address is formed by adding a base register and an offset register. For a matching word it produces three 4-bit register indices, a load or a store request, an access-size code and a sign-extension flag. The memory stage uses these to fetch or write a word, halfword or byte. The register file uses them too.

Several decoders, one per instruction class, feed the same result lines. They are merged by OR. For this reason, every output of this block is forced to zero whenever the word does not belong to its class or is not marked valid. The decode is registered: results appear one clock after the instruction is presented. Address arithmetic, the memory access itself and the register file are handled elsewhere.

Top module: `ldst_regoff_decoder`

## Requirements
- R1: `grp_active` is high one cycle after a clock edge at which `instr_valid` is high and `instr[15:12]` equals 4'b0101; otherwise it is low.
- R2: While active, `dst_idx` equals {1'b0, instr[2:0]}, `base_idx` equals {1'b0, instr[5:3]} and `offs_idx` equals {1'b0, instr[8:6]}, so bit 3 of every index is zero.
- R3: While active, the 3-bit opcode `instr[11:9]` selects a store (`store_req`) for values 000, 001 and 010, and a load (`load_req`) for 011 to 111; exactly one of the two is high.
- R4: While active, `acc_size` is 0 (word) for opcodes 000 and 100, 1 (halfword) for 001, 101 and 111, and 2 (byte) for 010, 011 and 110; the value 3 never appears.
- R5: While active, `sign_ext` is high only for opcodes 011 (signed byte load) and 111 (signed halfword load).
- R6: When `grp_active` is low, every other output is zero, so the OR-merged shared lines see no contribution from this block.
- R7: Each result follows its instruction by exactly one clock, and instructions presented on back-to-back cycles produce back-to-back results with no stall.
- R8: While `rst_n` is low at a clock edge, all outputs become zero on that edge, whatever the instruction input holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | The instruction word is meaningful this cycle |
| instr | input | 16 | Instruction word |
| grp_active | output | 1 | Registered: the word belongs to this class |
| dst_idx | output | 4 | Data register index (load target or store source) |
| base_idx | output | 4 | Base address register index |
| offs_idx | output | 4 | Offset register index |
| load_req | output | 1 | Load request |
| store_req | output | 1 | Store request |
| acc_size | output | 2 | 0 word, 1 halfword, 2 byte |
| sign_ext | output | 1 | Sign-extend the loaded value |

## Verification
The bench builds the block with its default parameters. These are a 16-bit word, 3-bit register fields widened to 4 bits, and the 4-bit class code 0101. With these values the whole opcode space can be swept against every class-code nibble, in 128 combinations. Register fields are driven at their all-zero and all-one extremes and with random values. The sweep also covers the near misses, where the code differs by one bit, and the valid-low and in-reset cases. A behavioural model compares every output on every clock, including a back-to-back stream that exposes any extra or missing pipeline stage.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the register-offset load/store decoder.
// Assumes the size encoding is fixed and understood by the memory stage.
package ldst_pkg;

    // Access width code as seen by the memory stage
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2
    } acc_size_e;

    // Decoded operation, before bus gating
    typedef struct packed {
        logic      load;
        logic      store;
        acc_size_e size;
        logic      sign;
    } ldst_op_t;

    localparam int OP_BITS = $bits(ldst_op_t);

endpackage

// File: rtl/ldst_group_match.sv
`timescale 1ns/1ps
// Module: ldst_group_match
// Flags an instruction as belonging to the register-offset load/store
// class when its top code field equals GRP_CODE and it is marked valid.
// Assumes the class code occupies the most significant bits of the word.
module ldst_group_match #(
    parameter int            INSTR_W    = 16,
    parameter int            GRP_CODE_W = 4,
    parameter logic [GRP_CODE_W-1:0] GRP_CODE = 4'b0101
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output logic               hit
);
    localparam int GRP_LSB = INSTR_W - GRP_CODE_W;

    // Compare the class-code field with the expected constant
    always_comb begin
        hit = valid && (instr[INSTR_W-1:GRP_LSB] == GRP_CODE);
    end
endmodule

// File: rtl/ldst_opcode_decode.sv
`timescale 1ns/1ps
// Module: ldst_opcode_decode
// Maps the 3-bit opcode onto the irregular set of direction, size and
// sign combinations. Only narrow loads may be signed, so three stores
// and five loads share the eight codes.
// Assumes OPC_W is 3; wider codes fall into the default arm as idle.
module ldst_opcode_decode
    import ldst_pkg::*;
#(
    parameter int OPC_W = 3
) (
    input  logic [OPC_W-1:0] opcode,
    output ldst_op_t         op
);
    // One arm per opcode: direction, width and sign together
    always_comb begin
        op = '0;
        unique case (opcode)
            3'b000:  begin op.store = 1'b1; op.size = SZ_WORD;                  end
            3'b001:  begin op.store = 1'b1; op.size = SZ_HALF;                  end
            3'b010:  begin op.store = 1'b1; op.size = SZ_BYTE;                  end
            3'b011:  begin op.load  = 1'b1; op.size = SZ_BYTE; op.sign = 1'b1;  end
            3'b100:  begin op.load  = 1'b1; op.size = SZ_WORD;                  end
            3'b101:  begin op.load  = 1'b1; op.size = SZ_HALF;                  end
            3'b110:  begin op.load  = 1'b1; op.size = SZ_BYTE;                  end
            3'b111:  begin op.load  = 1'b1; op.size = SZ_HALF; op.sign = 1'b1;  end
            default: op = '0;
        endcase
    end
endmodule

// File: rtl/ldst_bus_gate.sv
`timescale 1ns/1ps
// Module: ldst_bus_gate
// Releases a field onto an OR-merged shared line: passes the data when
// enabled and drives all zeros otherwise, the synthesizable stand-in
// for a tri-state driver. Assumes the other drivers also idle at zero.
module ldst_bus_gate #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Mask every bit with the enable
    always_comb begin
        q = d & {W{en}};
    end
endmodule

// File: rtl/ldst_regoff_decoder.sv
`timescale 1ns/1ps
// Module: ldst_regoff_decoder (top)
// Decodes the register-offset load/store class: register indices,
// load/store strobes, access size and sign flag, all zero when the word
// is outside the class. Results are registered, with one cycle of latency.
// Assumes the three low-register fields sit contiguously above bit 0 in
// the order data, base, offset, with the opcode above them.
module ldst_regoff_decoder
    import ldst_pkg::*;
#(
    parameter int INSTR_W    = 16,
    parameter int LOW_REG_W  = 3,
    parameter int REG_IDX_W  = 4,
    parameter int OPC_W      = 3,
    parameter int GRP_CODE_W = 4,
    parameter logic [GRP_CODE_W-1:0] GRP_CODE = 4'b0101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 grp_active,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [REG_IDX_W-1:0] base_idx,
    output logic [REG_IDX_W-1:0] offs_idx,
    output logic                 load_req,
    output logic                 store_req,
    output logic [1:0]           acc_size,
    output logic                 sign_ext
);
    localparam int N_REG_FIELDS = 3;
    localparam int OPC_LSB      = N_REG_FIELDS * LOW_REG_W;
    localparam int PAD_W        = REG_IDX_W - LOW_REG_W;

    logic                                    hit;
    ldst_op_t                                op_raw;
    logic [OP_BITS-1:0]                      op_gated;
    logic [N_REG_FIELDS-1:0][REG_IDX_W-1:0]  idx_wide;
    logic [N_REG_FIELDS-1:0][REG_IDX_W-1:0]  idx_gated;
    ldst_op_t                                op_g;

    ldst_group_match #(
        .INSTR_W    (INSTR_W),
        .GRP_CODE_W (GRP_CODE_W),
        .GRP_CODE   (GRP_CODE)
    ) u_match (
        .valid (instr_valid),
        .instr (instr),
        .hit   (hit)
    );

    ldst_opcode_decode #(
        .OPC_W (OPC_W)
    ) u_opdec (
        .opcode (instr[OPC_LSB +: OPC_W]),
        .op     (op_raw)
    );

    ldst_bus_gate #(
        .W (OP_BITS)
    ) u_gate_op (
        .en (hit),
        .d  (op_raw),
        .q  (op_gated)
    );

    // Widen each low-register field with zero padding, then gate it
    for (genvar gi = 0; gi < N_REG_FIELDS; gi++) begin : g_reg_field
        always_comb begin
            idx_wide[gi] = {{PAD_W{1'b0}}, instr[gi*LOW_REG_W +: LOW_REG_W]};
        end

        ldst_bus_gate #(
            .W (REG_IDX_W)
        ) u_gate_idx (
            .en (hit),
            .d  (idx_wide[gi]),
            .q  (idx_gated[gi])
        );
    end

    // View the gated operation vector as its struct
    always_comb begin
        op_g = ldst_op_t'(op_gated);
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_active <= 1'b0;
            dst_idx    <= '0;
            base_idx   <= '0;
            offs_idx   <= '0;
            load_req   <= 1'b0;
            store_req  <= 1'b0;
            acc_size   <= 2'd0;
            sign_ext   <= 1'b0;
        end else begin
            grp_active <= hit;
            dst_idx    <= idx_gated[0];
            base_idx   <= idx_gated[1];
            offs_idx   <= idx_gated[2];
            load_req   <= op_g.load;
            store_req  <= op_g.store;
            acc_size   <= op_g.size;
            sign_ext   <= op_g.sign;
        end
    end

    // ---------------- assertions ----------------
    // R1 / R7: a valid class word at one edge is reported at the next
    p_class_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[INSTR_W-1 -: GRP_CODE_W] == GRP_CODE) |=> grp_active);

    // R7: a non-class or invalid word leaves the block idle next cycle
    p_class_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && instr[INSTR_W-1 -: GRP_CODE_W] == GRP_CODE) |=> !grp_active);

    // R2: widened indices never name a high register
    p_low_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_active |-> (dst_idx[REG_IDX_W-1] == 1'b0 && base_idx[REG_IDX_W-1] == 1'b0
                        && offs_idx[REG_IDX_W-1] == 1'b0));

    // R3: exactly one request while active
    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_active |-> $onehot({load_req, store_req}));

    // R4: size code 3 never produced
    p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_size != 2'd3);

    // R5: sign extension only on narrow loads
    p_sign_narrow_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sign_ext |-> (load_req && acc_size != 2'd0));

    // R6: nothing driven onto the shared lines while idle
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_active |-> ({dst_idx, base_idx, offs_idx, load_req, store_req,
                          acc_size, sign_ext} == '0));

    // R8: reset at an edge clears the outputs
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!grp_active && !load_req && !store_req));
endmodule

// File: tb/ldst_regoff_decoder_bench.sv
`timescale 1ns/1ps
// Bench: drives one instruction per clock, keeps a behavioural expectation
// of the registered result and compares every output on every clock.
module ldst_regoff_decoder_bench;
    localparam real CLK_HALF = 2.0;          // 250 MHz
    localparam int  WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic        grp_active;
    logic [3:0]  dst_idx, base_idx, offs_idx;
    logic        load_req, store_req;
    logic [1:0]  acc_size;
    logic        sign_ext;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expectation for the outputs after the next edge
    bit have_exp = 0;
    int e_act, e_dst, e_base, e_offs, e_ld, e_st, e_sz, e_sg;
    string e_why;
    string phase = "";

    always #(CLK_HALF) clk = ~clk;

    ldst_regoff_decoder u_ldst_regoff_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .grp_active  (grp_active),
        .dst_idx     (dst_idx),
        .base_idx    (base_idx),
        .offs_idx    (offs_idx),
        .load_req    (load_req),
        .store_req   (store_req),
        .acc_size    (acc_size),
        .sign_ext    (sign_ext)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, phase, act, exp);
        end
    endtask

    // Reference: table written from the requirement text
    task automatic build_exp(input bit r, input bit v, input logic [15:0] w);
        int opc;
        e_act = 0; e_dst = 0; e_base = 0; e_offs = 0;
        e_ld = 0; e_st = 0; e_sz = 0; e_sg = 0;
        if (!r)                     e_why = "R8";
        else if (!(v && w[15:12] == 4'b0101)) e_why = "R6";
        else begin
            e_why = "";
            e_act  = 1;
            e_dst  = int'(w[2:0]);
            e_base = int'(w[5:3]);
            e_offs = int'(w[8:6]);
            opc = int'(w[11:9]);
            if (opc <= 2) e_st = 1; else e_ld = 1;
            case (opc)
                0, 4:    e_sz = 0;
                1, 5, 7: e_sz = 1;
                default: e_sz = 2;
            endcase
            e_sg = (opc == 3 || opc == 7) ? 1 : 0;
        end
    endtask

    task automatic compare_all();
        string t1, t2, t3, t4, t5;
        t1 = (e_why == "") ? "R1" : e_why;
        t2 = (e_why == "") ? "R2" : e_why;
        t3 = (e_why == "") ? "R3" : e_why;
        t4 = (e_why == "") ? "R4" : e_why;
        t5 = (e_why == "") ? "R5" : e_why;
        chk(t1, "grp_active", int'(grp_active), e_act);
        chk(t2, "dst_idx",    int'(dst_idx),    e_dst);
        chk(t2, "base_idx",   int'(base_idx),   e_base);
        chk(t2, "offs_idx",   int'(offs_idx),   e_offs);
        chk(t3, "load_req",   int'(load_req),   e_ld);
        chk(t3, "store_req",  int'(store_req),  e_st);
        chk(t4, "acc_size",   int'(acc_size),   e_sz);
        chk(t5, "sign_ext",   int'(sign_ext),   e_sg);
    endtask

    // One clock: check the result of the previous word, then drive the next
    task automatic step(input bit r, input bit v, input logic [15:0] w);
        @(negedge clk);
        if (have_exp) compare_all();
        rst_n = r; instr_valid = v; instr = w;
        build_exp(r, v, w);
        have_exp = 1;
    endtask

    function automatic logic [15:0] mk(input logic [3:0] top, input logic [2:0] opc,
                                       input logic [2:0] ro, input logic [2:0] rb,
                                       input logic [2:0] rd);
        return {top, opc, ro, rb, rd};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0;

        // R8: reset with a class word present still yields zeros
        phase = "R8 reset";
        step(0, 1, mk(4'b0101, 3'b100, 3'd7, 3'd7, 3'd7));
        step(0, 1, mk(4'b0101, 3'b011, 3'd5, 3'd2, 3'd1));
        step(0, 0, 16'h0000);

        // R3 R4 R5: every opcode with extreme and mixed register fields
        phase = "opcode sweep";
        for (int op = 0; op < 8; op++) begin
            step(1, 1, mk(4'b0101, 3'(op), 3'd0, 3'd0, 3'd0));
            step(1, 1, mk(4'b0101, 3'(op), 3'd7, 3'd7, 3'd7));
            step(1, 1, mk(4'b0101, 3'(op), 3'(op), 3'(7-op), 3'(op+3)));
        end

        // R6: single-bit-off class codes and invalid words
        phase = "R6 near misses";
        step(1, 1, mk(4'b0100, 3'b111, 3'd6, 3'd5, 3'd4));
        step(1, 1, mk(4'b0111, 3'b000, 3'd1, 3'd2, 3'd3));
        step(1, 1, mk(4'b1101, 3'b101, 3'd7, 3'd7, 3'd7));
        step(1, 1, mk(4'b0001, 3'b011, 3'd7, 3'd7, 3'd7));
        step(1, 0, mk(4'b0101, 3'b100, 3'd7, 3'd7, 3'd7));
        step(1, 0, mk(4'b0101, 3'b011, 3'd3, 3'd3, 3'd3));

        // R1 R6: all class codes against all opcodes
        phase = "code x opcode";
        for (int top = 0; top < 16; top++)
            for (int op = 0; op < 8; op++)
                step(1, 1, mk(4'(top), 3'(op), 3'(top), 3'(op), 3'(top + op)));

        // R7: back-to-back alternation of hits and misses
        phase = "R7 back-to-back";
        for (int i = 0; i < 40; i++)
            step(1, (i % 5) != 4, (i % 3 == 0) ? mk(4'b1010, 3'(i), 3'(i), 3'(i+1), 3'(i+2))
                                               : mk(4'b0101, 3'(i), 3'(i+2), 3'(i+1), 3'(i)));

        // random words, mid-run reset pulse included
        phase = "random";
        for (int i = 0; i < 300; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (i % 2 == 0) w[15:12] = 4'b0101;
            step((i % 97) != 50, 1'($urandom), w);
        end

        phase = "final";
        step(1, 0, 16'h0000);
        step(1, 0, 16'h0000);

        done = 1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_HALF * 2.0 * WD_CYCLES);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end
endmodule